// File: doc/BRIEF.md
# Network Status LED Driver

This block drives three active-low indicator pins for one 10/100 Ethernet port. Pin 0 shows line speed, pin 1 shows link state with an activity blink, and pin 2 shows full duplex. It takes level status inputs from the MAC/PHY (link up, 100 Mb/s, auto-negotiation busy, cable present, full duplex) and one-cycle transmit and receive strobes.

Every pin can instead act as a general-purpose I/O. A nine-bit configuration word picks, per pin, LED duty, input, push-pull output or open-drain output, and holds the output values. Each pin presents an output-enable and an output-value to its tri-state pad. A two-stage synchronized copy of the pad inputs is returned for reading.

The blink interval comes from a tick count that is derived from the clock frequency parameter and the interval length in milliseconds. This keeps the timing right at any clock. A test can lower the frequency parameter to shorten the interval.

Top module: `net_led_drv`

## Requirements
- R1: The speed indicator is on unless the port runs established 10 Mb/s: it is off only when link_up=1, cable_in=1, an_busy=0 and spd100=0 all hold together.
- R2: The link indicator is on while link_up=1 and no off interval is running. When link_up=0 it is off in the same cycle.
- R3: An activity strobe (tx_act or rx_act) seen at a clock edge while the link indicator rests on turns the indicator off from that edge for exactly T clock cycles, where T = (CLK_FREQ_HZ/1000)*BLINK_MS.
- R4: Each off interval is followed by an on interval of at least T cycles, and no new blink starts during it.
- R5: One or more strobes during an off or minimum-on interval lead to exactly one further off interval, which starts at the end of that minimum-on interval.
- R6: The duplex indicator is on exactly when link_up=1 and fdx=1.
- R7: The configuration word is written by cfg_we with cfg_wdata. Bits [2i+1:2i] give pin i's mode (00 LED, 01 input, 10 push-pull, 11 open-drain) and bit 6+i gives its output value. Reset loads 9'h1C0, so every pin starts in LED mode.
- R8: In LED mode a pin behaves as open drain: pin_out=0, and pin_oe=1 exactly when its indicator is on.
- R9: In input mode pin_oe=0 and pin_out=0. pin_rd[i] equals pin_in[i] from two clock edges earlier in every mode.
- R10: In push-pull mode pin_oe=1 and pin_out equals the pin's value bit.
- R11: In open-drain mode pin_out=0 and pin_oe is the inverse of the pin's value bit.
- R12: When the link drops, a running blink and any pending strobe are discarded. After the link returns, the indicator rests on until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Valid link |
| spd100 | input | 1 | Link runs at 100 Mb/s |
| an_busy | input | 1 | Auto-negotiation in progress |
| cable_in | input | 1 | Cable connected |
| fdx | input | 1 | Full-duplex operation |
| tx_act | input | 1 | One-cycle transmit activity strobe |
| rx_act | input | 1 | One-cycle receive activity strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 9 | Configuration write data |
| pin_in | input | 3 | Pad input values |
| pin_oe | output | 3 | Pad output enables |
| pin_out | output | 3 | Pad output values |
| pin_rd | output | 3 | Synchronized pad input read-back |

## Verification
A wrong blink state shows on pin 1's output enable. A missed or extra off interval, or one that is too short, differs from the reference within one cycle of the point where the expected edge should fall. A lost or doubled pending flag shows only when the minimum-on interval ends, so runs must last past that point. Configuration and synchronizer faults appear on the pad pins in the cycle after the write, or two cycles after the input change.

// File: rtl/net_led_drv.sv
module net_led_drv #(
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int BLINK_MS    = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up,
  input  logic       spd100,
  input  logic       an_busy,
  input  logic       cable_in,
  input  logic       fdx,
  input  logic       tx_act,
  input  logic       rx_act,
  input  logic       cfg_we,
  input  logic [8:0] cfg_wdata,
  input  logic [2:0] pin_in,
  output logic [2:0] pin_oe,
  output logic [2:0] pin_out,
  output logic [2:0] pin_rd
);
  localparam int NPIN  = 3;
  localparam int TICKS = (CLK_FREQ_HZ / 1000) * BLINK_MS;
  localparam int CW    = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  localparam logic [3*NPIN-1:0] CFG_RST = 9'h1C0;

  typedef enum logic [1:0] {BL_REST, BL_OFF, BL_HOLD} bl_t;

  bl_t             st;
  logic [CW-1:0]   cnt;
  logic            pend;
  logic [3*NPIN-1:0] cfg;
  logic [NPIN-1:0] s1, s2;
  logic [NPIN-1:0] led_on;

  wire act  = tx_act | rx_act;
  wire done = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !link_up) begin
      st   <= BL_REST;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      case (st)
        BL_REST: if (act) begin st <= BL_OFF; cnt <= '0; end
        BL_OFF: begin
          if (act) pend <= 1'b1;
          if (done) begin st <= BL_HOLD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        BL_HOLD: begin
          if (done) begin
            cnt  <= '0;
            pend <= 1'b0;
            st   <= (pend || act) ? BL_OFF : BL_REST;
          end else begin
            cnt <= cnt + 1'b1;
            if (act) pend <= 1'b1;
          end
        end
        default: st <= BL_REST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= CFG_RST;
      s1  <= '0;
      s2  <= '0;
    end else begin
      if (cfg_we) cfg <= cfg_wdata;
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  assign pin_rd    = s2;
  assign led_on[0] = !(link_up && cable_in && !an_busy && !spd100);
  assign led_on[1] = link_up && (st != BL_OFF);
  assign led_on[2] = link_up && fdx;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    wire [1:0] mode = cfg[2*i +: 2];
    wire       val  = cfg[2*NPIN + i];
    always_comb begin
      case (mode)
        2'b00:   begin pin_oe[i] = led_on[i]; pin_out[i] = 1'b0; end
        2'b01:   begin pin_oe[i] = 1'b0;      pin_out[i] = 1'b0; end
        2'b10:   begin pin_oe[i] = 1'b1;      pin_out[i] = val;  end
        default: begin pin_oe[i] = !val;      pin_out[i] = 1'b0; end
      endcase
    end

    p_drive_high_pp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out[i] |-> (mode == 2'b10));
    p_input_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> !pin_oe[i]);
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  p_sync_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (pin_rd == $past(pin_in, 2)));
  p_drop_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> !led_on[1]);
  p_off_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BL_OFF && !done && link_up) |=> (!led_on[1]));
  p_hold_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BL_HOLD && !done && link_up) |=> (led_on[1] || !link_up));
  p_rest_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BL_REST && link_up && act) |=> (st == BL_OFF || !link_up));
endmodule

// File: tb/net_led_drv_test.sv
module net_led_drv_test;
  localparam int FHZ = 10_000;
  localparam int T   = (FHZ / 1000) * 80;

  logic clk = 0, rst_n = 0;
  logic link_up = 0, spd100 = 0, an_busy = 0, cable_in = 0, fdx = 0;
  logic tx_act = 0, rx_act = 0, cfg_we = 0;
  logic [8:0] cfg_wdata = '0;
  logic [2:0] pin_in = '0;
  logic [2:0] pin_oe, pin_out, pin_rd;

  net_led_drv #(.CLK_FREQ_HZ(FHZ), .BLINK_MS(80)) uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .spd100(spd100),
    .an_busy(an_busy), .cable_in(cable_in), .fdx(fdx), .tx_act(tx_act),
    .rx_act(rx_act), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_rd(pin_rd));

  always #4 clk = ~clk;

  int vecs = 0, bad = 0;
  bit done_flag = 0;
  string ctx = "R7";

  int phase = 0, rem = 0, pend = 0;
  logic [8:0] m_cfg = 9'h1C0;
  logic [2:0] q1 = '0, q2 = '0;

  always @(posedge clk) begin
    bit a;
    a = tx_act | rx_act;
    if (!rst_n) begin
      m_cfg = 9'h1C0; q1 = '0; q2 = '0;
    end else begin
      if (cfg_we) m_cfg = cfg_wdata;
      q2 = q1; q1 = pin_in;
    end
    if (!rst_n || !link_up) begin
      phase = 0; rem = 0; pend = 0;
    end else if (phase == 0) begin
      if (a) begin phase = 1; rem = T; end
    end else if (phase == 1) begin
      if (a) pend = 1;
      rem--;
      if (rem == 0) begin phase = 2; rem = T; end
    end else begin
      rem--;
      if (rem == 0) begin
        if (pend || a) begin phase = 1; rem = T; end else phase = 0;
        pend = 0;
      end else if (a) pend = 1;
    end
    #2 compare();
  end

  task automatic compare();
    bit on [3];
    on[0] = !(link_up && cable_in && !an_busy && !spd100);
    on[1] = link_up && (phase != 1);
    on[2] = link_up && fdx;
    for (int i = 0; i < 3; i++) begin
      logic [1:0] md;
      logic v, eoe, eout;
      string tag;
      md = m_cfg[2*i +: 2];
      v  = m_cfg[6+i];
      case (md)
        2'b00: begin
          eoe = on[i]; eout = 0;
          tag = (i == 0) ? "R8 R1" : (i == 2) ? "R8 R6" :
                (phase == 1) ? "R8 R3" : (phase == 2) ? "R8 R4" : "R8 R2";
        end
        2'b01: begin eoe = 0; eout = 0; tag = "R9"; end
        2'b10: begin eoe = 1; eout = v; tag = "R10"; end
        default: begin eoe = !v; eout = 0; tag = "R11"; end
      endcase
      vecs++;
      if (pin_oe[i] !== eoe || pin_out[i] !== eout) begin
        bad++;
        $display("FAIL %s %s pin%0d oe/out actual %b%b expected %b%b at %0t",
                 ctx, tag, i, pin_oe[i], pin_out[i], eoe, eout, $time);
      end
    end
    if (rst_n) begin
      vecs++;
      if (pin_rd !== q2) begin
        bad++;
        $display("FAIL %s R9 pin_rd actual %b expected %b", ctx, pin_rd, q2);
      end
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(bit rx);
    if (rx) rx_act = 1; else tx_act = 1;
    tick(1);
    tx_act = 0; rx_act = 0;
  endtask

  task automatic wcfg(logic [8:0] w);
    cfg_we = 1; cfg_wdata = w; tick(1); cfg_we = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    ctx = "R7"; tick(3); rst_n = 1; tick(2);
    ctx = "R1";
    for (int k = 0; k < 16; k++) begin
      {link_up, cable_in, an_busy, spd100} = 4'(k); fdx = k[0]; tick(3);
    end
    link_up = 1; cable_in = 1; an_busy = 0; spd100 = 0; fdx = 1; tick(3);
    ctx = "R3"; strobe(0); tick(T + 20);
    ctx = "R4"; strobe(1); tick(T + 5); strobe(0); tick(T + 5);
    ctx = "R5"; tick(T); strobe(0); tick(10); strobe(1); strobe(0); tick(3 * T);
    ctx = "R5"; strobe(1); tick(T + 3); strobe(0); tick(3 * T);
    ctx = "R12"; strobe(0); tick(10); strobe(1); tick(5); link_up = 0; tick(5);
    link_up = 1; tick(2 * T + 10);
    ctx = "R12"; strobe(0); tick(T + 10); strobe(1); link_up = 0; tick(3);
    link_up = 1; tick(2 * T);
    ctx = "R9"; wcfg(9'b000_010101);
    for (int k = 0; k < 8; k++) begin pin_in = 3'(k); tick(1); end
    tick(4);
    ctx = "R10"; wcfg(9'b101_101010); tick(3); wcfg(9'b010_101010); tick(3);
    ctx = "R11"; wcfg(9'b101_111111); tick(3); wcfg(9'b010_111111); tick(3);
    ctx = "R8"; wcfg(9'b000_000000); tick(3);
    ctx = "mixed";
    for (int k = 0; k < 40000; k++) begin
      tx_act   = ($urandom_range(0, 99) < 2);
      rx_act   = ($urandom_range(0, 99) < 2);
      pin_in   = 3'($urandom);
      if ($urandom_range(0, 999) == 0) link_up = ~link_up;
      if ($urandom_range(0, 199) == 0) {cable_in, an_busy, spd100, fdx} = 4'($urandom);
      cfg_we = ($urandom_range(0, 1999) == 0);
      cfg_wdata = ($urandom_range(0, 1) == 1) ? 9'($urandom) : 9'h000;
      tick(1);
    end
    tx_act = 0; rx_act = 0; cfg_we = 0;
    ctx = "R7"; rst_n = 0; tick(2); rst_n = 1; tick(3);
    finish_run();
  end
endmodule